// File: doc/BRIEF.md
# Edge-Counting Accumulator with Overflow Flag

This block counts rising edges on an asynchronous input line and keeps a sticky overflow status bit. The line passes through a two-stage synchronizer. A rising-edge detector then turns each low-to-high transition into a single count pulse. The counter works in one of two modes. In wide mode all 16 bits count as one counter. In split mode only the low 8-bit stage advances while the high byte holds its value, so software can watch that stage on its own.

When the counter overflows, the status bit is set and an interrupt request can be raised. In split mode, an optional saturation setting makes the low stage stop at its top value instead of wrapping. In that setting, every further edge still sets the status bit. Software uses a small register bus with a one-bit address. Address 0 is the counter and address 1 is the status register. The status bit is cleared in one of two ways: by writing a one to it, or, when fast clearing is selected, by any access to the counter.

Top module: `pa_overflow_unit`

## Requirements
- R1: After reset, the count, the status bit, the interrupt request and the read data are all zero.
- R2: In wide mode (split_i=0), each rising edge on pin_i increments the 16-bit count by one. The new count appears on count_o three clock edges after pin_i rises (two synchronizer stages and the counter register). Holding pin_i high adds only one count.
- R3: In wide mode, an edge that takes the count from 0xFFFF to 0x0000 sets the status bit.
- R4: In split mode (split_i=1) with hold_i=0, only the low byte counts. An edge that takes the low byte from 0xFF to 0x00 leaves the high byte unchanged and sets the status bit.
- R5: In split mode with hold_i=1, the low byte stops at 0xFF. Every edge that arrives while the low byte is 0xFF sets the status bit and leaves the count unchanged.
- R6: With fclr_i=0, a write to address 1 with data bit 1 set clears the status bit. A write to address 1 with data bit 1 clear leaves the status bit unchanged.
- R7: With fclr_i=1, a write of one to data bit 1 at address 1 does not clear the status bit. Any read or write at address 0 clears it.
- R8: When an overflow event and a clear request fall in the same cycle, the status bit ends up set.
- R9: irq_o equals the status bit ANDed with ien_i, as ien_i was sampled on the edge that updated the status bit.
- R10: A read (rd_i=1) returns its data on rdata_o after the next clock edge, and rdata_o holds that value until the next read. Address 0 returns the count. Address 1 returns the status bit in bit 1 and zeros in all other bits.
- R11: A write to address 0 loads wdata_i into the counter. If an edge pulse arrives in the same cycle, the write wins and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous input line whose rising edges are counted |
| split_i | input | 1 | 1 = only the low 8-bit stage counts; 0 = all 16 bits count |
| hold_i | input | 1 | In split mode, 1 = low stage saturates at 0xFF |
| fclr_i | input | 1 | 1 = counter access clears the status bit; write-one clear is disabled |
| ien_i | input | 1 | Interrupt enable |
| addr_i | input | 1 | Register address: 0 = counter, 1 = status |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| count_o | output | 16 | Current count |
| flag_o | output | 1 | Overflow status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
A counter that lost or added a pulse shows up on count_o three cycles after the pin edge, and on rdata_o one cycle after a read. A wrong wrap or saturation decision shows up as a wrong low byte, a changed high byte, or a missing rise on flag_o, all visible on the very cycle the edge pulse is consumed. The two clear paths and the set-over-clear priority are checked by placing an access exactly on the cycle the edge pulse is consumed: a wrong priority leaves flag_o low one cycle later. irq_o is checked against flag_o on every cycle, so a stuck or stale interrupt shows within one cycle.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_STAT  = 1'b1;
  localparam int   STAT_BIT   = 1;
endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], line_i};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             split_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int HIGH_W = CNT_W - LOW_W;
  localparam logic [LOW_W-1:0] LOW_TOP  = '1;
  localparam logic [CNT_W-1:0] FULL_TOP = '1;

  logic [LOW_W-1:0]  low;
  logic [HIGH_W-1:0] high;
  logic              low_at_top;

  assign low        = count_o[LOW_W-1:0];
  assign high       = count_o[CNT_W-1:LOW_W];
  assign low_at_top = (low == LOW_TOP);

  always_comb begin
    ovf_o = 1'b0;
    if (step_i && !load_i)
      ovf_o = split_i ? low_at_top : (count_o == FULL_TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else if (load_i) begin
      count_o <= load_val_i;
    end else if (step_i) begin
      if (!split_i)
        count_o <= count_o + 1'b1;
      else if (!(low_at_top && hold_i))
        count_o <= {high, low + 1'b1};
    end
  end
endmodule

// File: rtl/pa_status.sv
module pa_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic w1c_i,
  input  logic touch_i,
  input  logic fclr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);
  logic clr, nxt;

  assign clr = fclr_i ? touch_i : w1c_i;
  assign nxt = set_i | (flag_o & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= nxt;
      irq_o  <= nxt & ien_i;
    end
  end
endmodule

// File: rtl/pa_overflow_unit.sv
module pa_overflow_unit #(
  parameter int CNT_W       = 16,
  parameter int LOW_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             split_i,
  input  logic             hold_i,
  input  logic             fclr_i,
  input  logic             ien_i,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  import pa_pkg::*;

  logic step, ovf, at_count, load, w1c, touch;
  logic [CNT_W-1:0] stat_word;

  assign at_count = (addr_i == ADDR_COUNT);
  assign load     = wr_i && at_count;
  assign touch    = (wr_i || rd_i) && at_count;
  assign w1c      = wr_i && (addr_i == ADDR_STAT) && wdata_i[STAT_BIT];

  pa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(pin_i), .rise_o(step)
  );

  pa_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .split_i(split_i), .hold_i(hold_i),
    .load_i(load), .load_val_i(wdata_i), .count_o(count_o), .ovf_o(ovf)
  );

  pa_status u_stat (
    .clk(clk), .rst(rst), .set_i(ovf), .w1c_i(w1c), .touch_i(touch),
    .fclr_i(fclr_i), .ien_i(ien_i), .flag_o(flag_o), .irq_o(irq_o)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[STAT_BIT] = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (rd_i)
      rdata_o <= at_count ? count_o : stat_word;
  end
endmodule

// File: rtl/pa_overflow_checker.sv
module pa_overflow_checker #(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             split_i,
  input logic             hold_i,
  input logic             fclr_i,
  input logic             ien_i,
  input logic             addr_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_TOP = '1;
  localparam logic [LOW_W-1:0] LOW_TOP  = '1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (count_o == '0 && !flag_o && !irq_o));

  assert_wide_wrap_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(split_i) && $past(count_o) == FULL_TOP && count_o == '0
     && !$past(wr_i && addr_i == 1'b0)) |-> flag_o);

  assert_hold_saturates_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(split_i) && $past(hold_i) && $past(count_o[LOW_W-1:0]) == LOW_TOP
     && !$past(wr_i && addr_i == 1'b0)) |-> count_o[LOW_W-1:0] == LOW_TOP);

  assert_fall_needs_access_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> $past(wr_i || rd_i));

  assert_fast_blocks_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(fclr_i) && $past(flag_o) && $past(addr_i == 1'b1)) |-> flag_o);

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_o && $past(ien_i)));
endmodule

bind pa_overflow_unit pa_overflow_checker #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_chk (
  .clk(clk), .rst(rst), .split_i(split_i), .hold_i(hold_i), .fclr_i(fclr_i),
  .ien_i(ien_i), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/test_pa_overflow_unit.sv
module test_pa_overflow_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_i = 1'b0, split_i = 1'b0, hold_i = 1'b0, fclr_i = 1'b0, ien_i = 1'b0;
  logic addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o, count_o;
  logic flag_o, irq_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pa_overflow_unit i_pa_overflow_unit (
    .clk(clk), .rst(rst), .pin_i(pin_i), .split_i(split_i), .hold_i(hold_i),
    .fclr_i(fclr_i), .ien_i(ien_i), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .count_o(count_o), .flag_o(flag_o),
    .irq_o(irq_o)
  );

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_EDGE = 2'd2} op_t;
  typedef struct packed {
    op_t         op;
    logic        addr;
    logic [15:0] data;
    logic [15:0] expv;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{OP_WR,   1'b0, 16'h00FE, 16'h0000},
    '{OP_EDGE, 1'b0, 16'h0000, 16'h00FF},  // R2 carries into bit 8 next
    '{OP_RD,   1'b0, 16'h0000, 16'h00FF},  // R10 counter read
    '{OP_RD,   1'b1, 16'h0000, 16'h0000},  // R10 status read, clear
    '{OP_WR,   1'b0, 16'hFFFF, 16'h0000},  // R11 load
    '{OP_EDGE, 1'b0, 16'h0000, 16'h0000},  // R3 wrap
    '{OP_RD,   1'b1, 16'h0000, 16'h0002},  // R3 status set
    '{OP_WR,   1'b1, 16'h00FD, 16'h0000},  // R6 bit1 clear: no effect
    '{OP_RD,   1'b1, 16'h0000, 16'h0002},
    '{OP_WR,   1'b1, 16'h0002, 16'h0000},  // R6 write-one clear
    '{OP_RD,   1'b1, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic a);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  // count settles three edges after the rise; returns at that point
  task automatic pin_rise();
    pin_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pin_fall();
    pin_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", count_o, 16'h0);
    check("R1 flag", {15'b0, flag_o}, 16'h0);
    check("R1 irq", {15'b0, irq_o}, 16'h0);
    check("R1 rdata", rdata_o, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        OP_WR: bus_wr(VEC[i].addr, VEC[i].data);
        OP_RD: begin
          bus_rd(VEC[i].addr);
          check($sformatf("R10 vector %0d read", i), rdata_o, VEC[i].expv);
        end
        default: begin
          pin_rise();
          check($sformatf("R2 vector %0d count", i), count_o, VEC[i].expv);
          pin_fall();
        end
      endcase
    end

    // R2: held high counts only once
    bus_wr(1'b0, 16'h0010);
    pin_rise();
    repeat (10) @(negedge clk);
    check("R2 held high", count_o, 16'h0011);
    pin_fall();

    // R11: load wins over a same-cycle edge pulse
    pin_i = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr(1'b0, 16'h0100);
    @(negedge clk);
    check("R11 load priority", count_o, 16'h0100);
    pin_fall();

    // R4: split wrap keeps high byte, sets flag
    split_i = 1'b1;
    bus_wr(1'b0, 16'h12FF);
    pin_rise();
    check("R4 split wrap count", count_o, 16'h1200);
    check("R4 split wrap flag", {15'b0, flag_o}, 16'h1);
    pin_fall();
    bus_wr(1'b1, 16'h0002);
    check("R6 clear after R4", {15'b0, flag_o}, 16'h0);

    // R5: saturation hold
    hold_i = 1'b1;
    bus_wr(1'b0, 16'h34FE);
    pin_rise(); pin_fall();
    check("R5 reach top", count_o, 16'h34FF);
    check("R5 no flag yet", {15'b0, flag_o}, 16'h0);
    pin_rise();
    check("R5 held count", count_o, 16'h34FF);
    check("R5 flag on extra edge", {15'b0, flag_o}, 16'h1);
    pin_fall();
    bus_wr(1'b1, 16'h0002);
    pin_rise();
    check("R5 flag again", {15'b0, flag_o}, 16'h1);
    pin_fall();
    hold_i = 1'b0; split_i = 1'b0;

    // R9: interrupt gating
    ien_i = 1'b1;
    @(negedge clk);
    check("R9 irq on", {15'b0, irq_o}, 16'h1);
    ien_i = 1'b0;
    @(negedge clk);
    check("R9 irq off", {15'b0, irq_o}, 16'h0);
    ien_i = 1'b1;

    // R7: fast clear
    fclr_i = 1'b1;
    bus_wr(1'b1, 16'h0002);
    check("R7 w1c ignored", {15'b0, flag_o}, 16'h1);
    bus_rd(1'b0);
    check("R7 read clears", {15'b0, flag_o}, 16'h0);
    check("R9 irq drops", {15'b0, irq_o}, 16'h0);

    // R8: set wins over same-cycle fast clear
    bus_wr(1'b0, 16'hFFFF);
    pin_i = 1'b1;
    repeat (2) @(negedge clk);
    rd_i = 1'b1; addr_i = 1'b0;
    @(negedge clk);
    rd_i = 1'b0;
    check("R8 set wins", {15'b0, flag_o}, 16'h1);
    check("R8 count wrapped", count_o, 16'h0000);
    check("R9 irq with set", {15'b0, irq_o}, 16'h1);
    pin_fall();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule